// File: doc/BRIEF.md
# NAND Single-Bit Hamming ECC Unit

This block sits beside a NAND data path and builds a 24-bit Hamming-style check code over one 512-byte data chunk while the bytes stream past on a byte-wide input qualified by a valid strobe. A restart pulse clears the running code and the byte position. The current code is always presented, bitwise inverted, as three bytes with the least significant byte on `code_b0`. Because of the inversion, a chunk of all-ones bytes produces the all-ones code that an erased page already holds in its spare area.

When a page is read back, the stored code is applied on the stored-code inputs and a compare strobe is given. One cycle later the block reports whether the chunk is clean, has one data bit in error (giving the byte index, the bit position and an XOR mask that repairs that byte), has a single bit flipped in the stored code itself, or cannot be corrected.

Top module: `nand_hamming_ecc`

## Requirements
- R1: While reset is asserted and right after it, the code bytes read 0xFF, `cmp_done` is 0 and `cmp_result` is 0.
- R2: Each data bit has a 12-bit address {byte index[8:0], bit position[2:0]}. Raw code bit k (k = 0..11) is the even parity of data bits whose address bit k is 0, and raw bit 12+k is the even parity of those whose address bit k is 1. The output code is the raw code inverted, with bits 7:0 on `code_b0`, 15:8 on `code_b1` and 23:16 on `code_b2`.
- R3: A chunk of 512 bytes of 0xFF yields the code 0xFFFFFF, and comparing it with a stored 0xFFFFFF reports no error.
- R4: `restart` clears the code to 0xFFFFFF and the byte position to 0 on the next edge; a byte offered in the same cycle as `restart` is dropped.
- R5: After 512 bytes have been taken since the last restart, further bytes leave the code unchanged.
- R6: A cycle with `in_valid` low leaves the code unchanged whatever `in_byte` carries.
- R7: `cmp_done` is high for exactly the cycle after each `cmp_strobe` cycle, and the result outputs hold their values until the next strobe.
- R8: With diff = calculated code XOR stored code, a zero diff gives `cmp_result` 0 (clean) with `fix_mask` 0.
- R9: When the upper 12 bits of diff XOR the lower 12 bits equal 0xFFF and diff[23:15] is below 512, `cmp_result` is 1 (data bit fixed), `fix_index` is diff[23:15], `fix_bit` is diff[14:12] and `fix_mask` has only that bit set.
- R10: When diff has exactly one bit set, `cmp_result` is 2 (fault in stored code) and `fix_mask` is 0.
- R11: Every other diff gives `cmp_result` 3 (uncorrectable) with `fix_mask` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Clears the code and the byte position |
| in_valid | input | 1 | Qualifies `in_byte` |
| in_byte | input | 8 | Data byte being streamed |
| code_b0 | output | 8 | Inverted code bits 7:0 |
| code_b1 | output | 8 | Inverted code bits 15:8 |
| code_b2 | output | 8 | Inverted code bits 23:16 |
| cmp_strobe | input | 1 | Starts a compare against the stored code |
| stored_b0 | input | 8 | Stored code bits 7:0 |
| stored_b1 | input | 8 | Stored code bits 15:8 |
| stored_b2 | input | 8 | Stored code bits 23:16 |
| cmp_done | output | 1 | One-cycle pulse, result valid |
| cmp_result | output | 2 | 0 clean, 1 data fixed, 2 code fault, 3 uncorrectable |
| fix_index | output | 9 | Byte index of the faulty data bit |
| fix_bit | output | 3 | Bit position of the faulty data bit |
| fix_mask | output | 8 | XOR mask that repairs the faulty byte |

## Verification
On every cycle the assertions hold the timing and shape rules: the done pulse that follows each strobe, results that stay put between strobes, a one-hot mask only for a fixed data bit, a code that resets on restart and stays frozen on idle cycles or once the chunk is full. Whether the code bits are the right parities, and whether each diff pattern lands in the right class with the right index and bit, only the bench scenarios can show, by feeding random and directed chunks and comparing against a bit-by-bit model of the parity definition.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

  typedef enum logic [1:0] {
    HECC_CLEAN      = 2'd0,
    HECC_DATA_FIX   = 2'd1,
    HECC_CODE_FAULT = 2'd2,
    HECC_UNCORR     = 2'd3
  } hecc_res_e;

  // Selects the byte lanes whose lane-number bit k is zero.
  function automatic logic [7:0] hecc_lane_mask(input int k);
    logic [7:0] m;
    for (int j = 0; j < 8; j++) begin
      m[j] = (((j >> k) & 1) == 0);
    end
    return m;
  endfunction

endpackage

// File: rtl/hecc_accum.sv
module hecc_accum #(
  parameter int CHUNK_BYTES = 512,
  parameter int IDX_W       = $clog2(CHUNK_BYTES),
  parameter int ADR_W       = IDX_W + 3,
  parameter int CNT_W       = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               in_valid,
  input  logic [7:0]         in_byte,
  output logic [2*ADR_W-1:0] par_q,
  output logic [CNT_W-1:0]   cnt_q
);
  import hecc_pkg::*;

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CHUNK_BYTES);

  logic               accept;
  logic               row_par;
  logic [2:0]         lane_lo;
  logic [2:0]         lane_hi;
  logic [ADR_W-1:0]   add_lo;
  logic [ADR_W-1:0]   add_hi;
  logic [2*ADR_W-1:0] par_d;
  logic [CNT_W-1:0]   cnt_d;
  logic               par_en;

  assign accept  = in_valid && (cnt_q < LIMIT);
  assign row_par = ^in_byte;

  for (genvar k = 0; k < 3; k++) begin : g_lane
    localparam logic [7:0] SEL = hecc_lane_mask(k);
    assign lane_lo[k] = ^(in_byte & SEL);
    assign lane_hi[k] = ^(in_byte & ~SEL);
  end

  always_comb begin
    add_lo[2:0] = lane_lo;
    add_hi[2:0] = lane_hi;
    for (int m = 0; m < IDX_W; m++) begin
      add_lo[3+m] = row_par & ~cnt_q[m];
      add_hi[3+m] = row_par &  cnt_q[m];
    end
  end

  always_comb begin
    par_en = restart || accept;
    par_d  = par_q;
    cnt_d  = cnt_q;
    if (restart) begin
      par_d = '0;
      cnt_d = '0;
    end else if (accept) begin
      par_d = par_q ^ {add_hi, add_lo};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= '0;
      cnt_q <= '0;
    end else if (par_en) begin
      par_q <= par_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/hecc_classify.sv
module hecc_classify #(
  parameter int CHUNK_BYTES = 512,
  parameter int IDX_W       = $clog2(CHUNK_BYTES),
  parameter int ADR_W       = IDX_W + 3,
  parameter int CODE_W      = 2 * ADR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_strobe,
  input  logic [CODE_W-1:0] calc_code,
  input  logic [CODE_W-1:0] stored_code,
  output logic              done_q,
  output logic [1:0]        res_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [2:0]        bit_q,
  output logic [7:0]        mask_q
);
  import hecc_pkg::*;

  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(CHUNK_BYTES);

  logic [CODE_W-1:0] diff;
  logic [ADR_W-1:0]  half_lo;
  logic [ADR_W-1:0]  half_hi;
  logic [IDX_W-1:0]  idx_d;
  logic [2:0]        bit_d;
  logic              fold_ok;
  logic              single;
  hecc_res_e         res_d;
  logic [IDX_W-1:0]  idx_n;
  logic [2:0]        bit_n;
  logic [7:0]        mask_n;

  assign diff    = calc_code ^ stored_code;
  assign half_lo = diff[ADR_W-1:0];
  assign half_hi = diff[CODE_W-1:ADR_W];
  assign idx_d   = half_hi[ADR_W-1:3];
  assign bit_d   = half_hi[2:0];
  assign fold_ok = ((half_hi ^ half_lo) == '1) && ({1'b0, idx_d} < LIMIT);
  assign single  = ((diff & (diff - 1'b1)) == '0);

  always_comb begin
    res_d  = HECC_UNCORR;
    idx_n  = '0;
    bit_n  = '0;
    mask_n = '0;
    if (diff == '0) begin
      res_d = HECC_CLEAN;
    end else if (fold_ok) begin
      res_d  = HECC_DATA_FIX;
      idx_n  = idx_d;
      bit_n  = bit_d;
      mask_n = 8'(1) << bit_d;
    end else if (single) begin
      res_d = HECC_CODE_FAULT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= cmp_strobe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= HECC_CLEAN;
      idx_q  <= '0;
      bit_q  <= '0;
      mask_q <= '0;
    end else if (cmp_strobe) begin
      res_q  <= res_d;
      idx_q  <= idx_n;
      bit_q  <= bit_n;
      mask_q <= mask_n;
    end
  end

endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc #(
  parameter int CHUNK_BYTES = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic [7:0] code_b0,
  output logic [7:0] code_b1,
  output logic [7:0] code_b2,
  input  logic       cmp_strobe,
  input  logic [7:0] stored_b0,
  input  logic [7:0] stored_b1,
  input  logic [7:0] stored_b2,
  output logic       cmp_done,
  output logic [1:0] cmp_result,
  output logic [8:0] fix_index,
  output logic [2:0] fix_bit,
  output logic [7:0] fix_mask
);

  localparam int IDX_W  = $clog2(CHUNK_BYTES);
  localparam int ADR_W  = IDX_W + 3;
  localparam int CODE_W = 2 * ADR_W;
  localparam int CNT_W  = IDX_W + 1;

  logic [CODE_W-1:0] par_q;
  logic [CNT_W-1:0]  byte_cnt;
  logic [CODE_W-1:0] calc_code;
  logic [CODE_W-1:0] stored_code;

  hecc_accum #(
    .CHUNK_BYTES(CHUNK_BYTES),
    .IDX_W      (IDX_W),
    .ADR_W      (ADR_W),
    .CNT_W      (CNT_W)
  ) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .in_valid(in_valid),
    .in_byte (in_byte),
    .par_q   (par_q),
    .cnt_q   (byte_cnt)
  );

  assign calc_code   = ~par_q;
  assign code_b0     = calc_code[7:0];
  assign code_b1     = calc_code[15:8];
  assign code_b2     = calc_code[23:16];
  assign stored_code = {stored_b2, stored_b1, stored_b0};

  hecc_classify #(
    .CHUNK_BYTES(CHUNK_BYTES),
    .IDX_W      (IDX_W),
    .ADR_W      (ADR_W),
    .CODE_W     (CODE_W)
  ) u_classify (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_strobe (cmp_strobe),
    .calc_code  (calc_code),
    .stored_code(stored_code),
    .done_q     (cmp_done),
    .res_q      (cmp_result),
    .idx_q      (fix_index),
    .bit_q      (fix_bit),
    .mask_q     (fix_mask)
  );

endmodule

// File: rtl/hecc_checker.sv
module hecc_checker #(
  parameter int CHUNK_BYTES = 512,
  parameter int CNT_W       = $clog2(CHUNK_BYTES) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             restart,
  input logic             in_valid,
  input logic [CNT_W-1:0] byte_cnt,
  input logic [23:0]      code_bytes,
  input logic             cmp_strobe,
  input logic             cmp_done,
  input logic [1:0]       cmp_result,
  input logic [7:0]       fix_mask
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CHUNK_BYTES);

  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe |=> cmp_done); // R7
  AST_DONE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_strobe |=> !cmp_done); // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_strobe |=> ($stable(cmp_result) && $stable(fix_mask))); // R7
  AST_FIX_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_result == 2'd1) |-> ($countones(fix_mask) == 1)); // R9
  AST_OTHER_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_result != 2'd1) |-> (fix_mask == 8'h00)); // R8
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (code_bytes == 24'hFFFFFF)); // R4
  AST_FULL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((byte_cnt == LIMIT) && !restart) |=> $stable(code_bytes)); // R5
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !restart) |=> $stable(code_bytes)); // R6

endmodule

bind nand_hamming_ecc hecc_checker #(
  .CHUNK_BYTES(CHUNK_BYTES),
  .CNT_W      (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .restart   (restart),
  .in_valid  (in_valid),
  .byte_cnt  (byte_cnt),
  .code_bytes({code_b2, code_b1, code_b0}),
  .cmp_strobe(cmp_strobe),
  .cmp_done  (cmp_done),
  .cmp_result(cmp_result),
  .fix_mask  (fix_mask)
);

// File: tb/nand_hamming_ecc_test.sv
module nand_hamming_ecc_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       restart;
  logic       in_valid;
  logic [7:0] in_byte;
  logic [7:0] code_b0, code_b1, code_b2;
  logic       cmp_strobe;
  logic [7:0] stored_b0, stored_b1, stored_b2;
  logic       cmp_done;
  logic [1:0] cmp_result;
  logic [8:0] fix_index;
  logic [2:0] fix_bit;
  logic [7:0] fix_mask;

  always #4 clk = ~clk;

  nand_hamming_ecc uut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .in_valid(in_valid),
    .in_byte(in_byte), .code_b0(code_b0), .code_b1(code_b1), .code_b2(code_b2),
    .cmp_strobe(cmp_strobe), .stored_b0(stored_b0), .stored_b1(stored_b1),
    .stored_b2(stored_b2), .cmp_done(cmp_done), .cmp_result(cmp_result),
    .fix_index(fix_index), .fix_bit(fix_bit), .fix_mask(fix_mask)
  );

  int checks = 0;
  int failures = 0;
  logic [7:0] mem [512];

  // Parity model straight from the bit-address definition (R2).
  function automatic logic [23:0] model_code(input int n);
    logic [23:0] raw = '0;
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < 8; j++) begin
        if (mem[i][j]) begin
          logic [11:0] a = {i[8:0], j[2:0]};
          for (int k = 0; k < 12; k++) begin
            if (a[k]) raw[12+k] = ~raw[12+k];
            else      raw[k]    = ~raw[k];
          end
        end
      end
    end
    return ~raw;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] cur_code();
    return {code_b2, code_b1, code_b0};
  endfunction

  task automatic do_restart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
  endtask

  task automatic feed(input int n, input int gap_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_valid = 1'b1; in_byte = mem[i];
      if (($urandom % 100) < gap_pct) begin
        @(negedge clk); in_valid = 1'b0; in_byte = 8'($urandom);
      end
    end
    @(negedge clk); in_valid = 1'b0; in_byte = 8'($urandom);
  endtask

  logic [1:0] r_res;
  logic [8:0] r_idx;
  logic [2:0] r_bit;
  logic [7:0] r_mask;

  task automatic compare(input logic [23:0] stored);
    @(negedge clk);
    {stored_b2, stored_b1, stored_b0} = stored;
    cmp_strobe = 1'b1;
    @(negedge clk);
    cmp_strobe = 1'b0;
    chk("R7 done pulse", 32'(cmp_done), 32'd1);
    r_res = cmp_result; r_idx = fix_index; r_bit = fix_bit; r_mask = fix_mask;
    stored_b0 = 8'($urandom);
    @(negedge clk);
    chk("R7 done single", 32'(cmp_done), 32'd0);
    chk("R7 result held", 32'(cmp_result), 32'(r_res));
  endtask

  task automatic fill_random();
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [23:0] good;
    int idx_list [5];
    int bit_list [5];
    void'($urandom(32'd1234));
    rst_n = 1'b0; restart = 1'b0; in_valid = 1'b0; in_byte = '0;
    cmp_strobe = 1'b0; stored_b0 = '0; stored_b1 = '0; stored_b2 = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset code", 32'(cur_code()), 32'hFFFFFF);
    chk("R1 reset done", 32'(cmp_done), 32'd0);
    chk("R1 reset result", 32'(cmp_result), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 code after reset", 32'(cur_code()), 32'hFFFFFF);

    // Full random chunk, clean compare
    fill_random();
    do_restart();
    feed(512, 30);
    good = model_code(512);
    chk("R2 full chunk code", 32'(cur_code()), 32'(good));
    compare(good);
    chk("R8 clean result", 32'(r_res), 32'd0);
    chk("R8 clean mask", 32'(r_mask), 32'd0);

    // Single data-bit errors: corners and random spots
    idx_list = '{0, 511, 256, 0, 0};
    bit_list = '{0, 7, 3, 0, 0};
    idx_list[3] = $urandom % 512; bit_list[3] = $urandom % 8;
    idx_list[4] = $urandom % 512; bit_list[4] = $urandom % 8;
    for (int t = 0; t < 5; t++) begin
      mem[idx_list[t]][bit_list[t]] = ~mem[idx_list[t]][bit_list[t]];
      do_restart();
      feed(512, 10);
      chk("R2 corrupted chunk code", 32'(cur_code()), 32'(model_code(512)));
      compare(good);
      chk("R9 fixed result", 32'(r_res), 32'd1);
      chk("R9 fixed index", 32'(r_idx), 32'(idx_list[t]));
      chk("R9 fixed bit", 32'(r_bit), 32'(bit_list[t]));
      chk("R9 fixed mask", 32'(r_mask), 32'(8'(1) << bit_list[t]));
      mem[idx_list[t]][bit_list[t]] = ~mem[idx_list[t]][bit_list[t]];
    end

    // Faults inside the stored code
    do_restart();
    feed(512, 0);
    foreach (bit_list[p]) begin end
    for (int p = 0; p < 24; p += 7) begin
      compare(good ^ (24'd1 << p));
      chk("R10 code fault result", 32'(r_res), 32'd2);
      chk("R10 code fault mask", 32'(r_mask), 32'd0);
    end
    compare(good ^ 24'h800000);
    chk("R10 code fault top bit", 32'(r_res), 32'd2);

    // Uncorrectable patterns
    compare(good ^ 24'h000003);
    chk("R11 two code bits", 32'(r_res), 32'd3);
    chk("R11 mask zero", 32'(r_mask), 32'd0);
    mem[5][1] = ~mem[5][1];
    mem[300][6] = ~mem[300][6];
    do_restart();
    feed(512, 20);
    compare(good);
    chk("R11 two data bits", 32'(r_res), 32'd3);
    mem[5][1] = ~mem[5][1];
    mem[300][6] = ~mem[300][6];

    // Erased chunk
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    do_restart();
    feed(512, 15);
    chk("R3 erased code", 32'(cur_code()), 32'hFFFFFF);
    compare(24'hFFFFFF);
    chk("R3 erased compare", 32'(r_res), 32'd0);

    // Overflow beyond one chunk
    fill_random();
    do_restart();
    feed(512, 5);
    good = model_code(512);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); in_valid = 1'b1; in_byte = 8'($urandom) | 8'h01;
    end
    @(negedge clk); in_valid = 1'b0;
    chk("R5 bytes past chunk ignored", 32'(cur_code()), 32'(good));

    // Partial chunk, then idle garbage
    do_restart();
    feed(37, 40);
    good = model_code(37);
    chk("R2 partial chunk code", 32'(cur_code()), 32'(good));
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); in_valid = 1'b0; in_byte = 8'($urandom);
    end
    @(negedge clk);
    chk("R6 idle bytes ignored", 32'(cur_code()), 32'(good));

    // Restart colliding with a valid byte
    @(negedge clk); restart = 1'b1; in_valid = 1'b1; in_byte = 8'h5A;
    @(negedge clk); restart = 1'b0; in_valid = 1'b0;
    chk("R4 restart drops byte", 32'(cur_code()), 32'hFFFFFF);
    feed(512, 25);
    chk("R4 position restarts at zero", 32'(cur_code()), 32'(model_code(512)));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule